// File: doc/BRIEF.md
# Dual-Output Reference Divider

This block divides a crystal-derived reference clock by a programmed ratio and hands the result to two phase-locked loops. It emits one single-cycle comparison strobe for loop A and one for loop B. The loop A strobe marks the rising point of an internal square wave, at the terminal count. The loop B strobe marks the falling point, at half count. Because the two strobes come from opposite halves of each division period, they never land in the same cycle, and the two loops' charge pumps fire at different times.

A select input halves loop B's comparison rate. With it set, only every second falling point produces a loop B strobe. The divider runs while at least one loop is enabled and the global run input is high. While both loops are off, or the global input is low, the counter is held at zero. When a loop is enabled again, counting restarts from a known phase, so the first comparison edges come at fixed distances from the enable and not at a random point of a stale count.

A new ratio is picked up only at a terminal count, so a division period is never cut short. A ratio below the legal minimum is raised to that minimum.

Top module: `dual_refdiv`

## Requirements
- R1: The ratio input is 12 bits wide. Legal ratios are 8 to 4095, and any value below 8 divides by 8.
- R2: With the select input low and both loops enabled, each strobe is a one-cycle pulse once every R clock cycles, where R is the effective ratio.
- R3: With the select input high, the loop A strobe keeps a period of R. The loop B strobe appears on every second falling point, so its period is 2R. The first falling point after a restart produces a loop B strobe.
- R4: The two strobes are never high in the same cycle. Within each period the loop B strobe comes floor(R/2) cycles after the start of the period and the loop A strobe comes R cycles after it (odd R rounds the half point down).
- R5: After a restart, the first loop B candidate strobe is high in the cycle after the floor(R/2)-th rising clock edge at which the divider is enabled. The first loop A strobe is high in the cycle after the R-th such edge.
- R6: When only one loop is enabled, the divider keeps its phase. The strobe of the disabled loop stays low, and the other strobe is unaffected even when a loop is switched off in the middle of a run.
- R7: A ratio change written during a run takes effect only after the next loop A strobe. The period in progress completes with the old ratio.
- R8: While the global run input is low, both strobes stay low whatever the per-loop enables are.
- R9: Synchronous active-high reset holds both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock derived from the crystal |
| rst | input | 1 | Synchronous reset, active high |
| ratio_i | input | 12 | Programmed division ratio R |
| half_b_i | input | 1 | 1 = loop B compares at half the loop A rate |
| sys_on_i | input | 1 | Global run enable; 0 = whole divider powered down |
| loop_a_on_i | input | 1 | Loop A enable |
| loop_b_on_i | input | 1 | Loop B enable |
| strobe_a_o | output | 1 | Loop A comparison strobe, one cycle wide |
| strobe_b_o | output | 1 | Loop B comparison strobe, one cycle wide |

## Verification
The bench numbers rising edges from the first edge at which the divider is enabled. The loop A strobe is due in the cycle after edge R and after every multiple of R. The loop B strobe is due after edge floor(R/2) plus a multiple of R, or plus an even multiple of R in half-rate mode. Both strobes are registered, so every expected value is computed for the cycle that follows its edge and is sampled on the falling clock edge of that cycle. In the ratio-change and loop-switch-off runs, the bench shifts the expected schedule at exactly the edge where the new ratio or the disabled loop applies.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    localparam int RATIO_W_DEF   = 12;
    localparam int MIN_RATIO_DEF = 8;

    // events produced by the counter in one cycle
    typedef struct packed {
        logic term;   // terminal count: square wave rises
        logic fall;   // half count: square wave falls
    } div_ev_t;

    typedef struct packed {
        logic a;
        logic b;
    } strobe_t;
endpackage

// File: rtl/ratio_latch.sv
module ratio_latch #(
    parameter int RATIO_W   = refdiv_pkg::RATIO_W_DEF,
    parameter int MIN_RATIO = refdiv_pkg::MIN_RATIO_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [RATIO_W-1:0] cur_o
);
    localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RATIO);

    logic [RATIO_W-1:0] clamped;

    always_comb begin
        clamped = (ratio_i < FLOOR) ? FLOOR : ratio_i;
    end

    always_ff @(posedge clk) begin
        if (rst)       cur_o <= FLOOR;
        else if (load) cur_o <= clamped;
    end

    // R1
    ratio_floor_chk: assert property (@(posedge clk) disable iff (rst)
        cur_o >= FLOOR);
endmodule

// File: rtl/div_counter.sv
module div_counter #(
    parameter int RATIO_W = refdiv_pkg::RATIO_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [RATIO_W-1:0]  cur_r,
    output refdiv_pkg::div_ev_t ev_o
);
    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] half_r;
    logic               sq_q;

    always_comb begin
        half_r    = cur_r >> 1;
        ev_o.term = run && (cnt == cur_r - RATIO_W'(1));
        ev_o.fall = run && (cnt == half_r - RATIO_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sq_q <= 1'b0;
        end else if (ev_o.term) begin
            cnt  <= '0;
            sq_q <= 1'b1;
        end else begin
            cnt <= cnt + RATIO_W'(1);
            if (ev_o.fall) sq_q <= 1'b0;
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < cur_r);
    // R5
    restart_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));
    // R2
    square_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ev_o.term |=> sq_q);
    // R4
    event_apart_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_o.term, ev_o.fall}));
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  refdiv_pkg::div_ev_t ev,
    input  logic                half_sel,
    input  logic                a_on,
    input  logic                b_on,
    output refdiv_pkg::strobe_t st_o
);
    logic skip_q;   // 1 = next falling point is skipped in half-rate mode

    always_ff @(posedge clk) begin
        if (rst || !run) skip_q <= 1'b0;
        else if (ev.fall) skip_q <= ~skip_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_o <= '0;
        end else begin
            st_o.a <= ev.term && a_on;
            st_o.b <= ev.fall && b_on && (!half_sel || !skip_q);
        end
    end

    // R4
    opposite_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !(st_o.a && st_o.b));
    // R6
    gate_a_chk: assert property (@(posedge clk) disable iff (rst)
        st_o.a |-> $past(a_on));
    // R6
    gate_b_chk: assert property (@(posedge clk) disable iff (rst)
        st_o.b |-> $past(b_on));
endmodule

// File: rtl/dual_refdiv.sv
module dual_refdiv #(
    parameter int RATIO_W   = refdiv_pkg::RATIO_W_DEF,
    parameter int MIN_RATIO = refdiv_pkg::MIN_RATIO_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               half_b_i,
    input  logic               sys_on_i,
    input  logic               loop_a_on_i,
    input  logic               loop_b_on_i,
    output logic               strobe_a_o,
    output logic               strobe_b_o
);
    logic                run;
    logic [RATIO_W-1:0]  cur_r;
    refdiv_pkg::div_ev_t ev;
    refdiv_pkg::strobe_t st;

    always_comb begin
        run = sys_on_i && (loop_a_on_i || loop_b_on_i);
    end

    ratio_latch #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)) u_ratio (
        .clk     (clk),
        .rst     (rst),
        .load    (!run || ev.term),
        .ratio_i (ratio_i),
        .cur_o   (cur_r)
    );

    div_counter #(.RATIO_W(RATIO_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .cur_r (cur_r),
        .ev_o  (ev)
    );

    strobe_gen u_strobe (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .ev       (ev),
        .half_sel (half_b_i),
        .a_on     (loop_a_on_i),
        .b_on     (loop_b_on_i),
        .st_o     (st)
    );

    assign strobe_a_o = st.a;
    assign strobe_b_o = st.b;

    // R2
    single_pulse_a_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_a_o |=> !strobe_a_o);
    // R8
    global_off_chk: assert property (@(posedge clk) disable iff (rst)
        !sys_on_i |=> !(strobe_a_o || strobe_b_o));
    // R7
    ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !ev.term) |=> $stable(cur_r));
endmodule

// File: tb/dual_refdiv_bench.sv
module dual_refdiv_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] ratio_i = 12'd8;
    logic        half_b_i = 1'b0;
    logic        sys_on_i = 1'b0;
    logic        loop_a_on_i = 1'b0;
    logic        loop_b_on_i = 1'b0;
    logic        strobe_a_o;
    logic        strobe_b_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_refdiv u_dual_refdiv (
        .clk         (clk),
        .rst         (rst),
        .ratio_i     (ratio_i),
        .half_b_i    (half_b_i),
        .sys_on_i    (sys_on_i),
        .loop_a_on_i (loop_a_on_i),
        .loop_b_on_i (loop_b_on_i),
        .strobe_a_o  (strobe_a_o),
        .strobe_b_o  (strobe_b_o)
    );

    function automatic int eff(input int r);
        return (r < 8) ? 8 : r;
    endfunction

    // expected {a,b} after edge n (1-based from enable)
    function automatic logic [1:0] expect_at(input int n, input int r1, input int r2,
                                             input bit half, input bit a, input bit b);
        int rr, m, bf, h;
        bit ea, eb;
        if (n <= r1) begin rr = r1; m = n;      bf = 0; end
        else         begin rr = r2; m = n - r1; bf = 1; end
        h  = rr / 2;
        ea = a && (m % rr == 0);
        eb = b && (m % rr == h) && (!half || (((bf + (m - h) / rr) % 2) == 0));
        return {ea, eb};
    endfunction

    task automatic run_seg(input string tag, input int r1, input int r2, input int chg_at,
                           input bit half, input bit on, input bit a, input bit b,
                           input int a_off_at, input int ncyc);
        int e1, e2, bad_a, bad_b, bad_x;
        bit act, a_cur;
        logic [1:0] ex;
        e1 = eff(r1);
        e2 = (chg_at != 0) ? eff(r2) : e1;
        sys_on_i = 1'b0; ratio_i = 12'(r1); half_b_i = half;
        loop_a_on_i = a; loop_b_on_i = b;
        repeat (3) @(negedge clk);
        sys_on_i = on;
        bad_a = 0; bad_b = 0; bad_x = 0;
        for (int n = 1; n <= ncyc; n++) begin
            if (chg_at != 0 && n == chg_at) ratio_i = 12'(r2);
            if (a_off_at != 0 && n == a_off_at) loop_a_on_i = 1'b0;
            a_cur = a && !(a_off_at != 0 && n >= a_off_at);
            act = on && (a_cur || b);
            @(posedge clk);
            @(negedge clk);
            ex = act ? expect_at(n, e1, e2, half, a_cur, b) : 2'b00;
            if (strobe_a_o !== ex[1]) begin
                if (bad_a == 0)
                    $display("FAIL %s strobe_a n=%0d R=%0d: got %0b expected %0b",
                             tag, n, e1, strobe_a_o, ex[1]);
                bad_a++;
            end
            if (strobe_b_o !== ex[0]) begin
                if (bad_b == 0)
                    $display("FAIL %s strobe_b n=%0d R=%0d: got %0b expected %0b",
                             tag, n, e1, strobe_b_o, ex[0]);
                bad_b++;
            end
            if (strobe_a_o === 1'b1 && strobe_b_o === 1'b1) begin
                if (bad_x == 0)
                    $display("FAIL R4 both strobes n=%0d: got 11 expected not 11", n);
                bad_x++;
            end
        end
        tests += 3;
        fails += (bad_a != 0) + (bad_b != 0) + (bad_x != 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired: got timeout expected completion");
        fails++;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int bad;
        void'($urandom(32'h5eed_0042));
        // R9: reset holds strobes low even with everything enabled
        sys_on_i = 1'b1; loop_a_on_i = 1'b1; loop_b_on_i = 1'b1;
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (strobe_a_o !== 1'b0 || strobe_b_o !== 1'b0) bad++;
        end
        tests++;
        if (bad != 0) begin
            fails++;
            $display("FAIL R9 reset: got %0b%0b expected 00", strobe_a_o, strobe_b_o);
        end
        sys_on_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // directed corners
        run_seg("R1 R2 clamp", 3, 3, 0, 1'b0, 1'b1, 1'b1, 1'b1, 0, 30);
        run_seg("R2 R4 R5 min", 8, 8, 0, 1'b0, 1'b1, 1'b1, 1'b1, 0, 40);
        run_seg("R3 R4 odd", 9, 9, 0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 50);
        run_seg("R1 R3 max", 4095, 4095, 0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 2*4095 + 2047 + 3);
        run_seg("R7 change", 20, 13, 5, 1'b0, 1'b1, 1'b1, 1'b1, 0, 20 + 13*3 + 8);
        run_seg("R7 change up", 10, 31, 3, 1'b1, 1'b1, 1'b1, 1'b1, 0, 10 + 31*3 + 8);
        run_seg("R6 a_off", 16, 16, 0, 1'b0, 1'b1, 1'b1, 1'b1, 20, 70);
        run_seg("R6 b_only", 12, 12, 0, 1'b1, 1'b1, 1'b0, 1'b1, 0, 60);
        run_seg("R8 global_off", 10, 10, 0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 40);

        // constrained random segments
        for (int k = 0; k < 8; k++) begin
            int r;
            bit h, on, a, b;
            r  = 8 + int'($urandom % 293);
            h  = 1'($urandom % 2);
            on = (($urandom % 4) != 0);
            a  = 1'($urandom % 2);
            b  = 1'($urandom % 2);
            run_seg("R2 R3 R5 R8 random", r, r, 0, h, on, a, b, 0, 2*r + r/2 + 3);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule